// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block holds the two counters of a pulse-swallow divider. It sits behind an external dual-modulus prescaler that divides the VCO by 64 or 65. The block runs on the prescaler output clock. During each divider cycle it keeps the prescaler in its divide-by-65 mode for the first A prescaler periods, then switches it to divide-by-64 for the rest of the N periods. It also raises a one-period output pulse for the phase detector in the last period of each cycle. The result is one output pulse for every 64·N + A VCO cycles.

The N and A values come from a latch elsewhere. They are sampled only when a cycle boundary occurs, so a new channel setting never corrupts a cycle that is already under way. An N below the minimum is raised to the minimum.

Top module: `pswallow_divider`

## Requirements
- R1: While `rst_n` is low, `mod_sel` and `div_pulse` are both 0. The first rising edge of `pre_clk` after reset is released samples `n_ratio` and `a_ratio` and begins the first divider cycle.
- R2: `mod_sel` is 1 (prescaler divides by 65) during the first A prescaler periods of each cycle and 0 (divides by 64) during the remaining periods of that cycle.
- R3: When A = 0, `mod_sel` stays 0 for the whole cycle.
- R4: `div_pulse` is 1 during exactly one prescaler period per cycle, the N-th and last one, and the next cycle starts at the following `pre_clk` edge.
- R5: For A < N, one cycle spans exactly 64·N + A VCO cycles, measured from one cycle start to the next.
- R6: An N value below 16, including 0, is treated as 16.
- R7: A change of `n_ratio` or `a_ratio` in the middle of a cycle does not affect that cycle. It takes effect at the next cycle boundary.
- R8: When A ≥ N, `mod_sel` stays 1 for the whole cycle, and the cycle spans 65·N VCO cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pre_clk | input | 1 | Prescaler output clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_ratio | input | 11 | Programmable-counter ratio N from the latch |
| a_ratio | input | 7 | Swallow-counter ratio A from the latch |
| mod_sel | output | 1 | Prescaler modulus select: 1 = divide by 65, 0 = divide by 64 |
| div_pulse | output | 1 | Divided output to the phase detector, one prescaler period wide |

## Verification
Several properties hold on every prescaler cycle, and the embedded assertions check them:
- the programmable count stays below the active N;
- the swallow count never passes A;
- once `mod_sel` falls it cannot rise again inside a cycle;
- the active ratios are stable between boundaries and never below 16;
- the output pulse is never longer than one period.

The overall division ratio can only be shown by the bench, because it depends on the external prescaler. The bench models that prescaler on the VCO clock and counts VCO cycles per output pulse. Only the bench's scenarios can show the clamp of small N, the A ≥ N case, the mid-cycle reprogramming and a reset in the middle of a cycle.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

   // Modulus request sent to the external dual-modulus prescaler
   typedef enum logic {
      MOD_LOW  = 1'b0,   // base ratio (64)
      MOD_HIGH = 1'b1    // base ratio + 1 (65)
   } modulus_e;

   localparam int PRESCALE_BASE = 64;

endpackage

// File: rtl/psw_ratio_hold.sv
module psw_ratio_hold #(
   parameter int N_W      = 11,
   parameter int A_W      = 7,
   parameter int N_MIN    = 16,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [N_W-1:0] n_in,
   input  logic [A_W-1:0] a_in,
   output logic [N_W-1:0] n_act,
   output logic [A_W-1:0] a_act,
   output logic           armed
);

   localparam logic [N_W-1:0] N_FLOOR = N_W'(N_MIN);

   logic [N_W-1:0] n_next;

   generate
      if (CLAMP_EN) begin : g_clamp
         always_comb n_next = (n_in < N_FLOOR) ? N_FLOOR : n_in;
      end else begin : g_pass
         always_comb n_next = n_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_act <= N_FLOOR;
         a_act <= '0;
         armed <= 1'b0;
      end else if (load) begin
         n_act <= n_next;
         a_act <= a_in;
         armed <= 1'b1;
      end
   end

   a_r6_min_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && CLAMP_EN) |-> (n_act >= N_FLOOR));

   a_r7_hold_midcycle: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !load) |=> ($stable(n_act) && $stable(a_act)));

endmodule

// File: rtl/psw_prog_ctr.sv
module psw_prog_ctr #(
   parameter int N_W = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           armed,
   input  logic [N_W-1:0] n_act,
   output logic           terminal
);

   logic [N_W-1:0] pcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pcnt <= '0;
      else if (load) pcnt <= '0;
      else           pcnt <= pcnt + 1'b1;
   end

   assign terminal = armed && (pcnt == (n_act - 1'b1));

   a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (pcnt < n_act));

   a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      terminal |=> (pcnt == '0));

endmodule

// File: rtl/psw_swallow_ctr.sv
module psw_swallow_ctr
   import pswallow_pkg::*;
#(
   parameter int A_W = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           armed,
   input  logic [A_W-1:0] a_act,
   output modulus_e       modulus
);

   logic [A_W-1:0] scnt;
   logic           swallowing;

   assign swallowing = armed && (scnt != a_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          scnt <= '0;
      else if (load)       scnt <= '0;
      else if (swallowing) scnt <= scnt + 1'b1;
   end

   assign modulus = swallowing ? MOD_HIGH : MOD_LOW;

   a_r2_swallow_cap: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (scnt <= a_act));

   a_r2_no_reraise: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !load && modulus == MOD_LOW) |=> (modulus == MOD_LOW));

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
   import pswallow_pkg::*;
#(
   parameter int N_W      = 11,
   parameter int A_W      = 7,
   parameter int N_MIN    = 16,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic           pre_clk,
   input  logic           rst_n,
   input  logic [N_W-1:0] n_ratio,
   input  logic [A_W-1:0] a_ratio,
   output logic           mod_sel,
   output logic           div_pulse
);

   generate
      if (N_W < 2 || A_W < 1) begin : g_bad_width
         $error("pswallow_divider: counter widths too small");
      end
      if (N_MIN < 2 || N_MIN >= (1 << N_W)) begin : g_bad_min
         $error("pswallow_divider: N_MIN must fit the programmable counter and exceed 1");
      end
   endgenerate

   logic [N_W-1:0] n_act;
   logic [A_W-1:0] a_act;
   logic           armed;
   logic           terminal;
   logic           load;
   modulus_e       modulus;

   // A cycle boundary: the last period of a cycle, or the first edge after reset
   assign load = terminal || !armed;

   psw_ratio_hold #(
      .N_W(N_W), .A_W(A_W), .N_MIN(N_MIN), .CLAMP_EN(CLAMP_EN)
   ) u_hold (
      .clk(pre_clk), .rst_n(rst_n), .load(load),
      .n_in(n_ratio), .a_in(a_ratio),
      .n_act(n_act), .a_act(a_act), .armed(armed)
   );

   psw_prog_ctr #(.N_W(N_W)) u_prog (
      .clk(pre_clk), .rst_n(rst_n), .load(load), .armed(armed),
      .n_act(n_act), .terminal(terminal)
   );

   psw_swallow_ctr #(.A_W(A_W)) u_swal (
      .clk(pre_clk), .rst_n(rst_n), .load(load), .armed(armed),
      .a_act(a_act), .modulus(modulus)
   );

   assign mod_sel   = (modulus == MOD_HIGH);
   assign div_pulse = terminal;

   a_r1_quiet_unarmed: assert property (@(posedge pre_clk) disable iff (!rst_n)
      !armed |-> (!mod_sel && !div_pulse));

   a_r4_single_period: assert property (@(posedge pre_clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

endmodule

// File: tb/pswallow_divider_bench.sv
module pswallow_divider_bench;

   logic        vco = 1'b0;
   logic        pre_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] n_ratio = 11'd16;
   logic [6:0]  a_ratio = 7'd0;
   logic        mod_sel;
   logic        div_pulse;

   int vectors = 0;
   int misses = 0;
   int pulses = 0;
   int vco_cycles = 0;
   string tag = "R5";

   // behavioural reference state
   bit m_armed = 0;
   int m_k = 0, m_n = 16, m_a = 0, acc = 0;
   int pdiv = 0, plen = 64;

   always #2 vco = ~vco;   // 250 MHz

   pswallow_divider u_pswallow_divider (
      .pre_clk(pre_clk), .rst_n(rst_n), .n_ratio(n_ratio), .a_ratio(a_ratio),
      .mod_sel(mod_sel), .div_pulse(div_pulse)
   );

   task automatic chk(input string req, input int act, input int exp, input string what);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Called once per prescaler period, just before pre_clk rises
   task automatic step_model();
      int exp_mod, exp_pulse, exp_len;
      if (!rst_n) begin
         chk("R1", mod_sel, 0, "mod_sel in reset");
         chk("R1", div_pulse, 0, "div_pulse in reset");
         m_armed = 0; acc = 0;
         return;
      end
      exp_mod   = (m_armed && m_k < m_a) ? 1 : 0;
      exp_pulse = (m_armed && m_k == m_n - 1) ? 1 : 0;
      chk((m_a >= m_n) ? "R8" : ((m_a == 0) ? "R3" : "R2"), mod_sel, exp_mod, "mod_sel");
      chk(m_armed ? "R4" : "R1", div_pulse, exp_pulse, "div_pulse");
      acc += plen;
      if (!m_armed || exp_pulse == 1) begin
         if (m_armed) begin
            exp_len = 64 * m_n + ((m_a < m_n) ? m_a : m_n);
            chk(tag, acc, exp_len, "VCO cycles per output pulse");
            pulses++;
         end
         m_armed = 1; m_k = 0; acc = 0;
         m_n = (n_ratio < 16) ? 16 : int'(n_ratio);
         m_a = int'(a_ratio);
      end else begin
         m_k++;
      end
   endtask

   // behavioural dual-modulus prescaler
   always @(posedge vco) begin
      if (pdiv == plen - 1) begin
         step_model();
         pre_clk <= 1'b1;
         pdiv <= 0;
      end else begin
         pdiv <= pdiv + 1;
         if (pdiv == 0)  plen <= mod_sel ? 65 : 64;
         if (pdiv == 31) pre_clk <= 1'b0;
      end
   end

   // watchdog
   always @(posedge vco) begin
      vco_cycles++;
      if (vco_cycles > 190000) begin
         misses++;
         $display("FAIL watchdog: actual %0d cycles expected completion", vco_cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   task automatic run(input int n, input int a, input int k, input string t);
      int target;
      @(negedge vco);
      n_ratio = 11'(n); a_ratio = 7'(a);
      target = pulses + 1;
      wait (pulses >= target);   // cycle already started with old values
      tag = t;
      target = pulses + k;
      wait (pulses >= target);
   endtask

   initial begin
      repeat (200) @(negedge vco);
      chk("R1", mod_sel, 0, "mod_sel after reset");
      chk("R1", div_pulse, 0, "div_pulse after reset");
      rst_n = 1'b1;

      run(16, 0, 2, "R3");
      run(20, 5, 2, "R5");
      run(16, 15, 2, "R5");
      run(40, 127, 2, "R8");
      run(16, 100, 2, "R8");
      run(5, 2, 2, "R6");
      run(0, 0, 2, "R6");
      run(33, 1, 2, "R5");

      // R7: reprogram in the middle of a cycle
      tag = "R7";
      run(24, 9, 1, "R7");
      repeat (700) @(negedge vco);
      n_ratio = 11'd30; a_ratio = 7'd3;
      begin
         int target = pulses + 2;
         wait (pulses >= target);
      end

      // R1: reset in the middle of a cycle
      repeat (500) @(negedge vco);
      rst_n = 1'b0;
      repeat (300) @(negedge vco);
      chk("R1", mod_sel, 0, "mod_sel mid-run reset");
      chk("R1", div_pulse, 0, "div_pulse mid-run reset");
      rst_n = 1'b1;
      tag = "R1";
      begin
         int target = pulses + 2;
         wait (pulses >= target);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule